// File: doc/BRIEF.md
# Masked Interrupt Status Register Group

This block is the interrupt register group of a clock and reset controller. It keeps one sticky status bit per interrupt source, a mask bit per source, and drives one level-sensitive interrupt line that is high whenever a status bit is set while its mask bit is clear. Hardware raises a status bit with a single-cycle pulse on `src_set`. Software clears status bits by writing ones to the status register.

The mask register cannot be written directly. Software unmasks sources by writing ones to the unmask command register, and masks them by writing ones to the mask command register. Neither command register stores anything. After reset every source is masked, so the line stays low until software has unmasked at least one source.

Access is through a simple 32-bit register bus. A write takes effect at the clock edge of the request cycle. A read request is answered one cycle later, with `bus_rvalid` high. The access sequencer has two named states. `ACC_IDLE` moves to `ACC_RDATA` on a read request. `ACC_RDATA` stays in `ACC_RDATA` on a back-to-back read request, and returns to `ACC_IDLE` otherwise. The line "Top module" below names the top of the design.

Top module: `irq_grp_top`

## Requirements
- R1: After reset, status reads 0, the mask has all implemented bits set (0x1 for one source, 0xF for four), `irq` is low and `bus_rvalid` is low.
- R2: `irq` is high exactly when some status bit is 1 while the mask bit at the same position is 0.
- R3: A one-cycle pulse on `src_set[i]` sets status bit i, and the bit then holds until software clears it.
- R4: A write to offset 0x00 (status) clears each status bit whose data bit is 1. Data bits that are 0 leave status unchanged.
- R5: When `src_set[i]` pulses in the same cycle as a status write with data bit i set, status bit i ends up set.
- R6: A write to offset 0x08 (unmask command) clears each mask bit whose data bit is 1, and leaves the other mask bits unchanged.
- R7: A write to offset 0x0C (mask command) sets each mask bit whose data bit is 1, and leaves the other mask bits unchanged.
- R8: Offset 0x04 reads the mask. A write to 0x04 does not change the mask.
- R9: Reads of offsets 0x08 and 0x0C always return zero.
- R10: Reads of an unmapped word offset return zero, and writes to one change neither status nor mask. Status and mask bits above the number of sources read as zero.
- R11: An access with `bus_addr[1:0]` not zero is not aligned. A write of this kind is ignored, and a read of this kind returns zero.
- R12: Read data is presented on `bus_rdata`, with `bus_rvalid` high, in the cycle after the read request cycle. `bus_rvalid` is low in every cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read response strobe |
| src_set | input | NUM_SRC | Per-source status set pulses |
| irq | output | 1 | Level interrupt output |

## Verification
The hardest case to reach from the ports is a hardware set pulse that lands in the very clock cycle in which software clears the same status bit. The bench uses one write task that also drives `src_set` during the write cycle, so that both events meet at a single edge. It then reads status back to show that the set took priority. The mask-only state is hard to reach as well, because the mask can only be seen by reading it. Each mask command and each ignored write is therefore followed by a read of the mask, and by a look at `irq` with a status bit deliberately left pending.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;

    localparam int unsigned OFS_STATUS  = 32'h00;
    localparam int unsigned OFS_MASK    = 32'h04;
    localparam int unsigned OFS_UNMASK  = 32'h08;
    localparam int unsigned OFS_DOMASK  = 32'h0C;

    typedef enum logic [0:0] {
        ACC_IDLE  = 1'b0,
        ACC_RDATA = 1'b1
    } acc_state_e;

    typedef enum logic [2:0] {
        RSEL_NONE   = 3'd0,
        RSEL_STATUS = 3'd1,
        RSEL_MASK   = 3'd2,
        RSEL_UNMASK = 3'd3,
        RSEL_DOMASK = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/irq_grp_decode.sv
module irq_grp_decode
    import irq_grp_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          rsel
);

    localparam int unsigned WORD_W = ADDR_W - 2;

    logic              aligned;
    logic [WORD_W-1:0] word;

    assign aligned = (addr[1:0] == 2'b00);
    assign word    = addr[ADDR_W-1:2];

    always_comb begin
        rsel = RSEL_NONE;
        if (aligned) begin
            if (word == WORD_W'(OFS_STATUS >> 2))      rsel = RSEL_STATUS;
            else if (word == WORD_W'(OFS_MASK >> 2))   rsel = RSEL_MASK;
            else if (word == WORD_W'(OFS_UNMASK >> 2)) rsel = RSEL_UNMASK;
            else if (word == WORD_W'(OFS_DOMASK >> 2)) rsel = RSEL_DOMASK;
        end
    end

endmodule

// File: rtl/irq_grp_access.sv
module irq_grp_access
    import irq_grp_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_SRC = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  reg_sel_e           rsel,
    input  logic [NUM_SRC-1:0] status,
    input  logic [NUM_SRC-1:0] mask,
    output logic               wr_status,
    output logic               wr_unmask,
    output logic               wr_domask,
    output logic [DATA_W-1:0]  rdata,
    output logic               rvalid
);

    acc_state_e       state_q, state_d;
    logic [DATA_W-1:0] rd_mux;
    logic              rd_req;

    assign rd_req = bus_sel && !bus_wr;

    always_comb begin
        wr_status = 1'b0;
        wr_unmask = 1'b0;
        wr_domask = 1'b0;
        if (bus_sel && bus_wr) begin
            unique case (rsel)
                RSEL_STATUS: wr_status = 1'b1;
                RSEL_UNMASK: wr_unmask = 1'b1;
                RSEL_DOMASK: wr_domask = 1'b1;
                default:     ;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (rsel)
            RSEL_STATUS: rd_mux[NUM_SRC-1:0] = status;
            RSEL_MASK:   rd_mux[NUM_SRC-1:0] = mask;
            default:     rd_mux = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE:  if (rd_req) state_d = ACC_RDATA;
            ACC_RDATA: state_d = rd_req ? ACC_RDATA : ACC_IDLE;
            default:   state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_req) rdata <= rd_mux;
        else             rdata <= '0;
    end

    assign rvalid = (state_q == ACC_RDATA);

    a_r12_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(bus_sel && !bus_wr));

    a_r12_read_gives_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> rvalid);

    a_r10_one_write_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_status, wr_unmask, wr_domask}));

    a_r11_no_write_when_read: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |-> !(wr_status || wr_unmask || wr_domask));

endmodule

// File: rtl/irq_grp_status.sv
module irq_grp_status #(
    parameter int unsigned NUM_SRC = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_clr,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [NUM_SRC-1:0] src_set,
    output logic [NUM_SRC-1:0] status
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)                 status[i] <= 1'b0;
            else if (src_set[i])        status[i] <= 1'b1;
            else if (wr_clr && wdata[i]) status[i] <= 1'b0;
        end

        a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            src_set[i] |=> status[i]);

        a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_clr && wdata[i] && !src_set[i]) |=> !status[i]);

        a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !(wr_clr && wdata[i])) |=> status[i]);
    end

endmodule

// File: rtl/irq_grp_mask.sv
module irq_grp_mask #(
    parameter int unsigned NUM_SRC = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_unmask,
    input  logic               wr_domask,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] mask
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)                     mask[i] <= 1'b1;
            else if (wr_domask && wdata[i]) mask[i] <= 1'b1;
            else if (wr_unmask && wdata[i]) mask[i] <= 1'b0;
        end

        a_r6_unmask_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_unmask && wdata[i]) |=> !mask[i]);

        a_r7_domask_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_domask && wdata[i]) |=> mask[i]);
    end

    a_r8_mask_only_by_command: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_unmask || wr_domask) |=> $stable(mask));

endmodule

// File: rtl/irq_grp_top.sv
module irq_grp_top
    import irq_grp_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_SRC = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_rvalid,
    input  logic [NUM_SRC-1:0] src_set,
    output logic               irq
);

    reg_sel_e           rsel;
    logic               wr_status, wr_unmask, wr_domask;
    logic [NUM_SRC-1:0] status, mask;

    irq_grp_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .rsel (rsel)
    );

    irq_grp_access #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .rsel      (rsel),
        .status    (status),
        .mask      (mask),
        .wr_status (wr_status),
        .wr_unmask (wr_unmask),
        .wr_domask (wr_domask),
        .rdata     (bus_rdata),
        .rvalid    (bus_rvalid)
    );

    irq_grp_status #(.NUM_SRC(NUM_SRC)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_clr  (wr_status),
        .wdata   (bus_wdata[NUM_SRC-1:0]),
        .src_set (src_set),
        .status  (status)
    );

    irq_grp_mask #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_unmask (wr_unmask),
        .wr_domask (wr_domask),
        .wdata     (bus_wdata[NUM_SRC-1:0]),
        .mask      (mask)
    );

    assign irq = |(status & ~mask);

    a_r1_masked_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!irq && (&mask)));

    a_r2_irq_drops_on_domask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_domask && (&bus_wdata[NUM_SRC-1:0]) && !(|src_set)) |=> !irq);

endmodule

// File: tb/tb_irq_grp_top.sv
`timescale 1ns/1ps
module tb_irq_grp_top;

    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned NUM_SRC = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_sel = 1'b0;
    logic               bus_wr = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [DATA_W-1:0]  bus_wdata = '0;
    logic [DATA_W-1:0]  bus_rdata;
    logic               bus_rvalid;
    logic [NUM_SRC-1:0] src_set = '0;
    logic               irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_grp_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .src_set(src_set), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; src_set = s;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; src_set = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        check("R12 rvalid in response cycle", {31'd0, bus_rvalid}, 32'd1);
        d = bus_rdata;
        @(negedge clk);
        check("R12 rvalid low after response", {31'd0, bus_rvalid}, 32'd0);
    endtask

    task automatic pulse_src(input logic [3:0] s);
        @(negedge clk);
        src_set = s;
        @(negedge clk);
        src_set = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 irq after reset", {31'd0, irq}, 32'd0);
        check("R1 rvalid after reset", {31'd0, bus_rvalid}, 32'd0);
        bus_read(8'h00, d); check("R1 status reset", d, 32'h0);
        bus_read(8'h04, d); check("R1 mask reset", d, 32'hF);
    endtask

    task automatic t_source_and_unmask;
        logic [31:0] d;
        pulse_src(4'b0001);
        repeat (3) @(negedge clk);
        bus_read(8'h00, d); check("R3 status held after pulse", d, 32'h1);
        check("R2 masked source keeps irq low", {31'd0, irq}, 32'd0);
        bus_write(8'h08, 32'h1, 4'b0);
        check("R2 irq high after unmask", {31'd0, irq}, 32'd1);
        bus_read(8'h04, d); check("R6 unmask clears only bit 0", d, 32'hE);
        bus_read(8'h08, d); check("R9 unmask command reads zero", d, 32'h0);
    endtask

    task automatic t_w1c;
        logic [31:0] d;
        bus_write(8'h00, 32'h0, 4'b0);
        bus_read(8'h00, d); check("R4 writing zero keeps status", d, 32'h1);
        check("R2 irq still high", {31'd0, irq}, 32'd1);
        bus_write(8'h00, 32'h1, 4'b0);
        bus_read(8'h00, d); check("R4 writing one clears status", d, 32'h0);
        check("R2 irq low after clear", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_set_wins;
        logic [31:0] d;
        bus_write(8'h00, 32'h4, 4'b0100);
        bus_read(8'h00, d); check("R5 set pulse beats clear", d, 32'h4);
        check("R2 bit 2 masked keeps irq low", {31'd0, irq}, 32'd0);
        bus_write(8'h08, 32'h4, 4'b0);
        check("R2 irq high after unmasking bit 2", {31'd0, irq}, 32'd1);
        bus_read(8'h04, d); check("R6 mask after second unmask", d, 32'hA);
    endtask

    task automatic t_domask;
        logic [31:0] d;
        bus_write(8'h0C, 32'h4, 4'b0);
        check("R7 irq low after masking bit 2", {31'd0, irq}, 32'd0);
        bus_read(8'h04, d); check("R7 mask after mask command", d, 32'hE);
        bus_read(8'h0C, d); check("R9 mask command reads zero", d, 32'h0);
    endtask

    task automatic t_mask_readonly;
        logic [31:0] d;
        bus_write(8'h04, 32'h0, 4'b0);
        bus_read(8'h04, d); check("R8 direct mask write ignored", d, 32'hE);
        check("R8 irq unchanged by mask write", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        bus_write(8'h10, 32'hFFFF_FFFF, 4'b0);
        bus_write(8'h40, 32'hFFFF_FFFF, 4'b0);
        bus_read(8'h10, d); check("R10 unmapped read zero", d, 32'h0);
        bus_read(8'h00, d); check("R10 status untouched by unmapped write", d, 32'h4);
        bus_read(8'h04, d); check("R10 mask untouched by unmapped write", d, 32'hE);
    endtask

    task automatic t_misaligned;
        logic [31:0] d;
        bus_write(8'h01, 32'hF, 4'b0);
        bus_write(8'h09, 32'hF, 4'b0);
        bus_read(8'h00, d); check("R11 misaligned status write ignored", d, 32'h4);
        bus_read(8'h04, d); check("R11 misaligned unmask ignored", d, 32'hE);
        bus_read(8'h05, d); check("R11 misaligned read zero", d, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_source_and_unmask();
        t_w1c();
        t_set_wins();
        t_domask();
        t_mask_readonly();
        t_unmapped();
        t_misaligned();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule